// File: doc/BRIEF.md
# Sprite and Tile Layer Priority Mixer

The block chooses one palette index per pixel from up to six sources. Four tile layers each supply a 4-bit colour and a 3-bit palette bank. A sprite line buffer supplies a colour, a 4-bit priority and a 4-bit bank. A text overlay pixel can also take part. The result is the palette index of the frontmost opaque source. Colour value 0 is transparent in every source. When nothing is opaque, the result is colour 0 of a backdrop bank. The index is registered, so it appears one clock after its inputs.

The block also holds the sprite line buffer, one entry per horizontal pixel. A sprite renderer writes its pixels into this buffer. Where sprites overlap, a write rule keeps the sprite with the smaller priority number. A strobe at the start of each line clears every entry. The display path reads the entry at the current pixel column. The sprite priority value decides where the sprite falls in the tile-layer stack.

Top module: `layer_mixer`

## Requirements
- R1: `pal_idx` is `{bank, colour}` zero-extended to 10 bits and is registered: inputs present before a rising edge are reflected after that edge. Reset drives `pal_idx` to 0.
- R2: Tile layer k (k = 1..4) uses `tile_pix[4k-1:4k-4]` and `tile_bank[3k-1:3k-3]`. Layer 4 is in front and layer 1 is at the back. Colour 0 is transparent.
- R3: `layer_en` bit k-1 enables layer k. A disabled layer is transparent whatever its colour.
- R4: An opaque sprite with priority 0 or 1 is in front of all tile layers. Priority 2 or 3 places it behind layer 4 and in front of layer 3. Priority 4 or 5 places it behind layer 3 and in front of layer 2. Priority 6 or 7 places it behind layer 2 and in front of layer 1.
- R5: An opaque sprite with priority 8 to 15 is behind all four tile layers.
- R6: When `text_on` is 1, a text pixel with a nonzero colour wins over every tile and sprite pixel. When `text_on` is 0, or the text colour is 0, the text input has no effect.
- R7: When no source is opaque, `pal_idx` = `{backdrop_bank, 4'b0000}`.
- R8: A write with nonzero colour replaces the line-buffer entry when that entry is transparent, or when the new priority is strictly smaller than the stored one. Otherwise the entry is kept, so on equal priority the earlier sprite stays. A write with colour 0 changes nothing. Writes at `wr_x >= LINE_W` are ignored.
- R9: `line_start` sets every line-buffer entry to colour 0, priority 15. It takes precedence over a write in the same cycle. Reset has the same effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Clears the sprite line buffer |
| wr_en | input | 1 | Sprite pixel write strobe |
| wr_x | input | XW | Line-buffer column to write |
| wr_color | input | 4 | Sprite colour (0 = transparent) |
| wr_prio | input | 4 | Sprite priority |
| wr_bank | input | 4 | Sprite palette bank |
| rd_x | input | XW | Line-buffer column for the current pixel |
| layer_en | input | 4 | Per-layer enables, bit 0 = layer 1 |
| tile_pix | input | 16 | Four tile colours, layer 1 in bits 3:0 |
| tile_bank | input | 12 | Four tile banks, layer 1 in bits 2:0 |
| text_on | input | 1 | Text overlay enable |
| text_color | input | 4 | Text pixel colour |
| text_bank | input | 4 | Text palette bank |
| backdrop_bank | input | 4 | Bank used when all sources are transparent |
| pal_idx | output | 10 | Registered palette index of the winning pixel |

## Verification
The hardest state to reach from the ports is a line-buffer entry whose contents depend on a sequence of overlapping writes. Examples are a tie in priority, a transparent write over an opaque one, and a write landing in the same cycle as the line clear. The bench reaches these states with short directed write sequences to a single column. It then reads that column back through the mixer with every tile layer transparent and the text overlay off. In that setting the output index shows exactly which sprite colour, bank and priority the entry holds. The priority band boundaries are covered by table vectors that put a sprite on each side of every tile layer.

// File: rtl/layer_mixer.sv
module layer_mixer #(
  parameter int LINE_W = 320,
  parameter int XW = $clog2(LINE_W),
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          wr_en,
  input  logic [XW-1:0] wr_x,
  input  logic [3:0]    wr_color,
  input  logic [3:0]    wr_prio,
  input  logic [3:0]    wr_bank,
  input  logic [XW-1:0] rd_x,
  input  logic [3:0]    layer_en,
  input  logic [15:0]   tile_pix,
  input  logic [11:0]   tile_bank,
  input  logic          text_on,
  input  logic [3:0]    text_color,
  input  logic [3:0]    text_bank,
  input  logic [3:0]    backdrop_bank,
  output logic [IW-1:0] pal_idx
);
  localparam int NL = 4;
  localparam logic [XW:0] LIM = LINE_W[XW:0];
  localparam logic [11:0] EMPTY = {4'h0, 4'hF, 4'h0};

  logic [11:0] lb [LINE_W];
  logic [11:0] cur, rd_ent;
  logic        wr_ok, wr_take;
  logic [3:0]  rd_c, rd_p, rd_b;
  logic [2:0]  slot;
  logic [NL-1:0] opq;
  logic [IW-1:0] win;
  logic        hit;

  assign wr_ok   = {1'b0, wr_x} < LIM;
  assign cur     = wr_ok ? lb[wr_x] : EMPTY;
  assign wr_take = wr_en && wr_ok && (wr_color != 4'h0) &&
                   ((cur[3:0] == 4'h0) || (wr_prio < cur[7:4]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINE_W; i++) lb[i] <= EMPTY;
    end else if (line_start) begin
      for (int i = 0; i < LINE_W; i++) lb[i] <= EMPTY;
    end else if (wr_take) begin
      lb[wr_x] <= {wr_bank, wr_prio, wr_color};
    end
  end

  assign rd_ent = ({1'b0, rd_x} < LIM) ? lb[rd_x] : EMPTY;
  assign rd_c = rd_ent[3:0];
  assign rd_p = rd_ent[7:4];
  assign rd_b = rd_ent[11:8];
  assign slot = rd_p[3] ? 3'd4 : {1'b0, rd_p[2:1]};

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_opq
      assign opq[g] = layer_en[g] && (tile_pix[g*4 +: 4] != 4'h0);
    end
  endgenerate

  always_comb begin
    win = IW'({backdrop_bank, 4'h0});
    hit = 1'b0;
    if (text_on && text_color != 4'h0) begin
      win = IW'({text_bank, text_color});
      hit = 1'b1;
    end
    for (int j = NL - 1; j >= 0; j--) begin
      if (!hit && rd_c != 4'h0 && int'(slot) == NL - 1 - j) begin
        win = IW'({rd_b, rd_c});
        hit = 1'b1;
      end
      if (!hit && opq[j]) begin
        win = IW'({tile_bank[j*3 +: 3], tile_pix[j*4 +: 4]});
        hit = 1'b1;
      end
    end
    if (!hit && rd_c != 4'h0) win = IW'({rd_b, rd_c});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pal_idx <= '0;
    else        pal_idx <= win;
  end
endmodule

module layer_mixer_chk #(
  parameter int LINE_W = 320,
  parameter int XW = 9,
  parameter int IW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic          wr_en,
  input logic [XW-1:0] wr_x,
  input logic [3:0]    wr_color,
  input logic [XW-1:0] rd_x,
  input logic [3:0]    rd_c,
  input logic [3:0]    rd_p,
  input logic [3:0]    rd_b,
  input logic [3:0]    layer_en,
  input logic          text_on,
  input logic [3:0]    text_color,
  input logic [3:0]    text_bank,
  input logic [3:0]    backdrop_bank,
  input logic [IW-1:0] pal_idx
);
  localparam logic [XW:0] LIM = LINE_W[XW:0];

  a_r6_text_front: assert property (@(posedge clk) disable iff (!rst_n)
    (text_on && text_color != 4'h0) |=> pal_idx == $past(IW'({text_bank, text_color})));

  a_r4_sprite_top: assert property (@(posedge clk) disable iff (!rst_n)
    (!text_on && rd_c != 4'h0 && rd_p < 4'd2) |=> pal_idx == $past(IW'({rd_b, rd_c})));

  a_r7_backdrop: assert property (@(posedge clk) disable iff (!rst_n)
    (!text_on && layer_en == 4'h0 && rd_c == 4'h0) |=> pal_idx == $past(IW'({backdrop_bank, 4'h0})));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (rd_c == 4'h0 && rd_p == 4'hF));

  a_r8_fill_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !line_start && wr_x == rd_x && {1'b0, rd_x} < LIM && wr_color != 4'h0 && rd_c == 4'h0)
    |=> (rd_x != $past(rd_x) || rd_c == $past(wr_color)));
endmodule

bind layer_mixer layer_mixer_chk #(.LINE_W(LINE_W), .XW(XW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .wr_en(wr_en), .wr_x(wr_x),
  .wr_color(wr_color), .rd_x(rd_x), .rd_c(rd_c), .rd_p(rd_p), .rd_b(rd_b),
  .layer_en(layer_en), .text_on(text_on), .text_color(text_color),
  .text_bank(text_bank), .backdrop_bank(backdrop_bank), .pal_idx(pal_idx)
);

// File: tb/layer_mixer_bench.sv
module layer_mixer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 320;
  localparam int XW = $clog2(LINE_W);
  localparam int NV = 23;
  // {layer_en, tile_pix L4..L1, spr colour, spr prio, text_on, text colour, expected}
  localparam logic [42:0] VEC [NV] = '{
    {4'hF, 16'h0000, 4'd0, 4'd0,  1'b0, 4'd0, 10'h070}, // R7
    {4'hF, 16'h0009, 4'd0, 4'd0,  1'b0, 4'd0, 10'h019}, // R2
    {4'hF, 16'h3209, 4'd0, 4'd0,  1'b0, 4'd0, 10'h043}, // R2
    {4'hF, 16'h0209, 4'd0, 4'd0,  1'b0, 4'd0, 10'h032}, // R2
    {4'hF, 16'h5555, 4'd6, 4'd0,  1'b0, 4'd0, 10'h0A6}, // R4
    {4'hF, 16'h5555, 4'd6, 4'd1,  1'b0, 4'd0, 10'h0A6}, // R4
    {4'hF, 16'h5555, 4'd6, 4'd2,  1'b0, 4'd0, 10'h045}, // R4
    {4'hF, 16'h0555, 4'd6, 4'd3,  1'b0, 4'd0, 10'h0A6}, // R4
    {4'hF, 16'h0555, 4'd6, 4'd4,  1'b0, 4'd0, 10'h035}, // R4
    {4'hF, 16'h0055, 4'd6, 4'd5,  1'b0, 4'd0, 10'h0A6}, // R4
    {4'hF, 16'h0055, 4'd6, 4'd6,  1'b0, 4'd0, 10'h025}, // R4
    {4'hF, 16'h0005, 4'd6, 4'd7,  1'b0, 4'd0, 10'h0A6}, // R4
    {4'hF, 16'h0005, 4'd6, 4'd8,  1'b0, 4'd0, 10'h015}, // R5
    {4'hF, 16'h0000, 4'd6, 4'd8,  1'b0, 4'd0, 10'h0A6}, // R5
    {4'hF, 16'h0005, 4'd6, 4'd15, 1'b0, 4'd0, 10'h015}, // R5
    {4'hF, 16'h0000, 4'd6, 4'd12, 1'b0, 4'd0, 10'h0A6}, // R5
    {4'h7, 16'h5000, 4'd0, 4'd0,  1'b0, 4'd0, 10'h070}, // R3
    {4'hE, 16'h0005, 4'd6, 4'd8,  1'b0, 4'd0, 10'h0A6}, // R3
    {4'h5, 16'h5555, 4'd0, 4'd0,  1'b0, 4'd0, 10'h035}, // R3
    {4'hF, 16'h5555, 4'd6, 4'd0,  1'b1, 4'd9, 10'h0C9}, // R6
    {4'hF, 16'h5555, 4'd6, 4'd0,  1'b1, 4'd0, 10'h0A6}, // R6
    {4'hF, 16'h5555, 4'd0, 4'd0,  1'b0, 4'd9, 10'h045}, // R6
    {4'hF, 16'h0000, 4'd0, 4'd0,  1'b1, 4'd0, 10'h070}  // R6 R7
  };

  logic clk = 0, rst_n = 0, line_start = 0, wr_en = 0, text_on = 0;
  logic [XW-1:0] wr_x = '0, rd_x = '0;
  logic [3:0] wr_color = 0, wr_prio = 0, wr_bank = 4'hA, layer_en = 0;
  logic [15:0] tile_pix = 0;
  logic [11:0] tile_bank = {3'd4, 3'd3, 3'd2, 3'd1};
  logic [3:0] text_color = 0, text_bank = 4'hC, backdrop_bank = 4'h7;
  logic [9:0] pal_idx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_mixer u_layer_mixer (.*);

  task automatic check(string req, logic [9:0] got, logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pal_idx=%h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_line();
    @(negedge clk); line_start = 1;
    @(negedge clk); line_start = 0;
  endtask

  task automatic put(int x, logic [3:0] c, logic [3:0] p, logic [3:0] b);
    @(negedge clk); wr_en = 1; wr_x = XW'(x); wr_color = c; wr_prio = p; wr_bank = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic look(string req, int x, logic [9:0] exp);
    @(negedge clk); rd_x = XW'(x); layer_en = 4'hF; tile_pix = 0; text_on = 0;
    @(negedge clk); check(req, pal_idx, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", pal_idx, 10'h000);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clear_line();
      put(5, VEC[v][22:19], VEC[v][18:15], 4'hA);
      @(negedge clk);
      rd_x = XW'(5); layer_en = VEC[v][42:39]; tile_pix = VEC[v][38:23];
      text_on = VEC[v][14]; text_color = VEC[v][13:10];
      @(negedge clk);
      check($sformatf("R2-table vector %0d", v), pal_idx, VEC[v][9:0]);
    end
    text_on = 0; text_color = 0;

    // R1 latency: old value holds until the next edge
    @(negedge clk); layer_en = 4'hF; tile_pix = 16'h7000;
    #1 check("R1 before edge", pal_idx, 10'h070);
    @(negedge clk); check("R1 after edge", pal_idx, 10'h047);

    // R8 overlap rule on one column
    clear_line();
    put(10, 4'd3, 4'd5, 4'hA);
    look("R8 first write", 10, 10'h0A3);
    put(10, 4'd4, 4'd2, 4'hA);
    look("R8 lower prio replaces", 10, 10'h0A4);
    put(10, 4'd7, 4'd9, 4'hA);
    look("R8 higher prio kept out", 10, 10'h0A4);
    put(10, 4'd8, 4'd2, 4'hA);
    look("R8 tie keeps earlier", 10, 10'h0A4);
    put(10, 4'd0, 4'd0, 4'hA);
    look("R8 transparent write ignored", 10, 10'h0A4);
    put(10, 4'd1, 4'd0, 4'h5);
    look("R8 replace with new bank", 10, 10'h051);
    look("R8 neighbour untouched", 11, 10'h070);
    put(LINE_W - 1, 4'd2, 4'd3, 4'hA);
    look("R8 last column", LINE_W - 1, 10'h0A2);

    // R9 clear
    clear_line();
    look("R9 cleared", 10, 10'h070);
    look("R9 last column cleared", LINE_W - 1, 10'h070);
    put(10, 4'd2, 4'd15, 4'hA);
    look("R9 cleared prio accepts 15", 10, 10'h0A2);
    @(negedge clk); line_start = 1; wr_en = 1; wr_x = XW'(12); wr_color = 4'd6; wr_prio = 4'd0;
    @(negedge clk); line_start = 0; wr_en = 0;
    look("R9 clear beats write", 12, 10'h070);
    look("R9 clear wipes old entry", 10, 10'h070);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule